// File: doc/BRIEF.md
# PHY Interrupt Flag Controller with Qualified Clearing

This block gathers nine PHY status indications into a latched flag register, gates them with a mask register, and drives a single registered interrupt line. Each flag is set by an edge of its status input. Most flags set on a rising edge. The link-lost flag sets on a falling edge of link status. A wake source is derived from an 8-bit wake control word: each of the four enable bits is paired with a status bit, and the four pairs are ORed together.

Software clears flags by reading the flag register. For each flag that is set, the read only takes effect if the condition behind that flag has gone away at that moment. A flag whose cause is still present survives the read, and so does the interrupt it drives. The status generators themselves sit outside the block and appear here as plain level inputs.

Top module: `phy_irq_flag_ctrl`

## Requirements
- R1: While reset is held and after it, before any event, the flag register (address 29) and the mask register (address 30) read 0x0000 and `irq_o` is 0.
- R2: Flag bits are placed as follows: page received = 1, parallel-detect fault = 2, partner acknowledge = 3, remote fault = 5, negotiation done = 6, energy present = 7, wake = 8. Each of these flags sets on a rising edge of its input.
- R3: Bit 9 (link up) sets on a rising edge of `link_i`. Bit 4 (link lost) sets on a falling edge of `link_i`.
- R4: The wake source is high when `wake_ctl_i[7:4] & wake_ctl_i[3:0]` is non-zero. Enables without matching status bits, or status bits without matching enables, do not raise it.
- R5: A read strobe to address 29 clears every set flag whose de-assert condition holds in that cycle. For bit 4 the condition is `link_i` high. For every other bit the condition is its source low.
- R6: A set flag whose de-assert condition does not hold survives the read, and `irq_o` stays asserted while that flag is unmasked.
- R7: When a flag's set edge and a clearing read fall in the same cycle, the flag ends up set.
- R8: `irq_o` is the OR of all flags ANDed with their mask bits, registered. A mask change reaches `irq_o` one clock after the write takes effect.
- R9: Bit 0 and bits 15:10 of both registers always read 0, and writes to those bits of the mask are dropped. A write to the flag register has no effect.
- R10: An energy input that is already high when reset is released sets flag 7 on the first clock after release.
- R11: Without a read to address 29, a set flag never clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_i | input | 1 | Internal link status level |
| energy_i | input | 1 | Energy-present level |
| neg_done_i | input | 1 | Auto-negotiation complete level |
| rem_fault_i | input | 1 | Remote fault level |
| lp_ack_i | input | 1 | Link-partner acknowledge level |
| pd_fault_i | input | 1 | Parallel-detect fault level |
| page_rx_i | input | 1 | Page received level |
| wake_ctl_i | input | 8 | Wake control word: [7:4] enables, [3:0] status |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address (29 flags, 30 mask) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A clearing read and a new set edge on the same flag can land in the same clock. A clearing read and a still-active cause can also coincide. The bench provokes both cases. It first leaves flag 1 set with its source low. It then raises that source, and toggles link status, in the very cycle of the read. Flag 1 must stay set, flag 4 must clear, and flag 9 must appear, all judged on the next read of address 29. The stimulus table also performs a read on every step while some causes are still high, and each readout is compared with values derived by hand from the requirements.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int REG_W = 16;

    // flag bit positions (software decodes these)
    localparam int B_PGRX = 1;
    localparam int B_PDF  = 2;
    localparam int B_ACK  = 3;
    localparam int B_LDN  = 4;
    localparam int B_RFLT = 5;
    localparam int B_ANC  = 6;
    localparam int B_NRG  = 7;
    localparam int B_WAKE = 8;
    localparam int B_LUP  = 9;

    localparam int LO_BIT = B_PGRX;
    localparam int HI_BIT = B_LUP;

    localparam logic [REG_W-1:0] VALID_MASK =
        ((REG_W'(1) << (HI_BIT + 1)) - REG_W'(1)) & ~((REG_W'(1) << LO_BIT) - REG_W'(1));

    // sources that set on a falling edge of their input
    localparam logic [REG_W-1:0] FALL_MASK = REG_W'(1) << B_LDN;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic link;
        logic energy;
        logic neg_done;
        logic rem_fault;
        logic lp_ack;
        logic pd_fault;
        logic page_rx;
        logic wake;
    } phy_status_t;

    function automatic logic [REG_W-1:0] pack_sources(input phy_status_t s);
        logic [REG_W-1:0] v;
        v         = '0;
        v[B_PGRX] = s.page_rx;
        v[B_PDF]  = s.pd_fault;
        v[B_ACK]  = s.lp_ack;
        v[B_LDN]  = s.link;
        v[B_RFLT] = s.rem_fault;
        v[B_ANC]  = s.neg_done;
        v[B_NRG]  = s.energy;
        v[B_WAKE] = s.wake;
        v[B_LUP]  = s.link;
        return v;
    endfunction

endpackage

// File: rtl/phy_irq_wake_merge.sv
module phy_irq_wake_merge #(
    parameter int GROUPS = 4,
    localparam int CTL_W = 2 * GROUPS
) (
    input  logic [CTL_W-1:0] ctl_i,
    output logic             hit_o
);
    logic [GROUPS-1:0] pair;

    always_comb begin
        pair  = ctl_i[CTL_W-1:GROUPS] & ctl_i[GROUPS-1:0];
        hit_o = |pair;
    end
endmodule

// File: rtl/phy_irq_flag_cell.sv
module phy_irq_flag_cell #(
    parameter bit FALL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic clr_req_i,
    output logic flag_o
);
    logic src_q;
    logic set_ev;
    logic cause;

    always_comb begin
        if (FALL) begin
            set_ev = src_q & ~src_i;
            cause  = ~src_i;
        end else begin
            set_ev = src_i & ~src_q;
            cause  = src_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            src_q <= src_i;
            if (set_ev) begin
                flag_o <= 1'b1;
            end else if (clr_req_i && !cause) begin
                flag_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 5'd29,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 5'd30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  flags_i,
    output logic [REG_W-1:0]  mask_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              clr_req_o
);
    reg_sel_e sel;

    always_comb begin
        if (addr_i == FLAG_ADDR) begin
            sel = SEL_FLAG;
        end else if (addr_i == MASK_ADDR) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '0;
        end else if (wr_i && sel == SEL_MASK) begin
            mask_o <= wdata_i & VALID_MASK;
        end
    end

    always_comb begin
        case (sel)
            SEL_FLAG: rdata_o = flags_i & VALID_MASK;
            SEL_MASK: rdata_o = mask_o;
            default:  rdata_o = '0;
        endcase
        clr_req_o = rd_i && (sel == SEL_FLAG);
    end
endmodule

// File: rtl/phy_irq_flag_ctrl.sv
module phy_irq_flag_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int FLAG_ADDR = 29,
    parameter int MASK_ADDR = 30,
    parameter int WAKE_GRP  = 4,
    localparam int WCTL_W   = 2 * WAKE_GRP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_i,
    input  logic              energy_i,
    input  logic              neg_done_i,
    input  logic              rem_fault_i,
    input  logic              lp_ack_i,
    input  logic              pd_fault_i,
    input  logic              page_rx_i,
    input  logic [WCTL_W-1:0] wake_ctl_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    logic             wake_hit;
    phy_status_t      status;
    logic [REG_W-1:0] src_vec;
    logic [REG_W-1:0] flag_vec;
    logic [REG_W-1:0] mask_q;
    logic             clr_req;

    phy_irq_wake_merge #(.GROUPS(WAKE_GRP)) u_wake (
        .ctl_i (wake_ctl_i),
        .hit_o (wake_hit)
    );

    always_comb begin
        status.link      = link_i;
        status.energy    = energy_i;
        status.neg_done  = neg_done_i;
        status.rem_fault = rem_fault_i;
        status.lp_ack    = lp_ack_i;
        status.pd_fault  = pd_fault_i;
        status.page_rx   = page_rx_i;
        status.wake      = wake_hit;
        src_vec          = pack_sources(status);
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (VALID_MASK[i]) begin : g_cell
            phy_irq_flag_cell #(.FALL(FALL_MASK[i])) u_cell (
                .clk       (clk),
                .rst       (rst),
                .src_i     (src_vec[i]),
                .clr_req_i (clr_req),
                .flag_o    (flag_vec[i])
            );
        end else begin : g_zero
            assign flag_vec[i] = 1'b0;
        end
    end

    phy_irq_regs #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (ADDR_W'(FLAG_ADDR)),
        .MASK_ADDR (ADDR_W'(MASK_ADDR))
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .rd_i      (reg_rd_i),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .flags_i   (flag_vec),
        .mask_o    (mask_q),
        .rdata_o   (reg_rdata_o),
        .clr_req_o (clr_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(flag_vec & mask_q);
        end
    end
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk
    import phy_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] src,
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] mask,
    input logic             clr_req,
    input logic             irq,
    input logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] prev;
    logic [REG_W-1:0] edge_c;
    logic [REG_W-1:0] cause_c;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= src;
    end

    always_comb begin
        edge_c  = ((src & ~prev & ~FALL_MASK) | (~src & prev & FALL_MASK)) & VALID_MASK;
        cause_c = (src ^ FALL_MASK) & VALID_MASK;
    end

    // R2 R3 R7
    set_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_c != '0) |=> ((flags & $past(edge_c)) == $past(edge_c)));

    // R6
    blocked_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> ((flags & $past(flags & cause_c)) == $past(flags & cause_c)));

    // R5
    clear_ok_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> ((flags & $past(flags & ~cause_c & ~edge_c)) == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_req |=> ((~flags & $past(flags)) == '0));

    // R8
    irq_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == (|$past(flags & mask))));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~VALID_MASK) == '0);
endmodule

bind phy_irq_flag_ctrl phy_irq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .src     (src_vec),
    .flags   (flag_vec),
    .mask    (mask_q),
    .clr_req (clr_req),
    .irq     (irq_o),
    .rdata   (reg_rdata_o)
);

// File: tb/tb_phy_irq_flag_ctrl.sv
module tb_phy_irq_flag_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_i = 0, energy_i = 1, neg_done_i = 0, rem_fault_i = 0;
    logic        lp_ack_i = 0, pd_fault_i = 0, page_rx_i = 0;
    logic [7:0]  wake_ctl_i = '0;
    logic        reg_rd_i = 0, reg_wr_i = 0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    phy_irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .link_i(link_i), .energy_i(energy_i),
        .neg_done_i(neg_done_i), .rem_fault_i(rem_fault_i), .lp_ack_i(lp_ack_i),
        .pd_fault_i(pd_fault_i), .page_rx_i(page_rx_i), .wake_ctl_i(wake_ctl_i),
        .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        link;
        logic        energy;
        logic        anc;
        logic        rflt;
        logic        ack;
        logic        pdf;
        logic        pgrx;
        logic [7:0]  wake;
        logic [15:0] exp;
    } vec_t;

    // each row: drive levels, one clock, then a clearing read whose readout is exp
    localparam vec_t TBL [10] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0200}, // link up rises
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,16'h0202}, // page rx, both held
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0212}, // link falls -> bit 4
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0250}, // link back, neg done
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,16'h026C}, // faults and ack
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h22,16'h032C}, // wake pair matches
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hF0,16'h0310}, // enables only
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h0F,16'h0090}, // status only, energy
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0290}, // link up again
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0210}  // link down again
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_flags(input string tag, input logic [15:0] exp);
        reg_addr_i = 5'd29;
        reg_rd_i   = 1'b1;
        #1;
        check(tag, reg_rdata_o, exp);
        tick();
        reg_rd_i   = 1'b0;
        reg_addr_i = 5'd0;
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [15:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        tick();
        reg_wr_i    = 1'b0;
        reg_addr_i  = 5'd0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // reset, energy already high
        repeat (3) tick();
        reg_addr_i = 5'd29; #1;
        check("R1 flags in reset", reg_rdata_o, 16'h0000);
        reg_addr_i = 5'd30; #1;
        check("R1 mask in reset", reg_rdata_o, 16'h0000);
        check("R1 irq in reset", {15'd0, irq_o}, 16'h0000);
        reg_addr_i = 5'd0;
        rst = 1'b0;
        tick();
        read_flags("R10 energy flag after reset", 16'h0080);
        read_flags("R6 energy still high, clear blocked", 16'h0080);
        energy_i = 1'b0;
        read_flags("R5 flag readout before clear", 16'h0080);
        read_flags("R5 energy low, cleared", 16'h0000);

        // table walk: R2 R3 R4 R5 R6
        foreach (TBL[k]) begin
            link_i      = TBL[k].link;
            energy_i    = TBL[k].energy;
            neg_done_i  = TBL[k].anc;
            rem_fault_i = TBL[k].rflt;
            lp_ack_i    = TBL[k].ack;
            pd_fault_i  = TBL[k].pdf;
            page_rx_i   = TBL[k].pgrx;
            wake_ctl_i  = TBL[k].wake;
            tick();
            read_flags($sformatf("R2 R3 R4 R5 R6 table row %0d", k), TBL[k].exp);
        end

        // flags now 0x0010 (link lost held, link low); mask is zero
        check("R8 masked flag gives no irq", {15'd0, irq_o}, 16'h0000);
        write_reg(5'd30, 16'hFFFF);
        reg_addr_i = 5'd30; #1;
        check("R9 mask reserved bits dropped", reg_rdata_o, 16'h03FE);
        reg_addr_i = 5'd0;
        write_reg(5'd29, 16'hFFFF);
        read_flags("R9 flag write ignored", 16'h0010);
        check("R8 unmasked flag raises irq", {15'd0, irq_o}, 16'h0001);
        write_reg(5'd30, 16'h03EE);
        check("R8 irq lags mask write", {15'd0, irq_o}, 16'h0001);
        tick();
        check("R8 irq drops after mask", {15'd0, irq_o}, 16'h0000);
        write_reg(5'd30, 16'h03FE);

        // collision: set edge on bit 1 in the clearing-read cycle
        page_rx_i = 1'b1; tick();
        page_rx_i = 1'b0; tick();
        page_rx_i = 1'b1;
        link_i    = 1'b1;
        read_flags("R11 flag 1 held without read", 16'h0012);
        read_flags("R7 edge beats clear, bit 4 cleared, bit 9 set", 16'h0202);
        tick();
        check("R6 irq stays with active causes", {15'd0, irq_o}, 16'h0001);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule